// File: doc/BRIEF.md
# Stack-Pointer Extended Instruction Executor

This block decodes and runs a small group of extra instructions for a compact 8-bit microcontroller datapath. The instructions work on a 12-bit software stack pointer. One group changes the pointer by a literal and then returns from a subroutine. Another group pushes a literal byte. A third group copies one byte in data memory, from a location relative to the stack to either an absolute address or a second stack-relative location. The block takes 16-bit instruction words from a fetch interface, one word for each accepted request. It drives a data-memory port whose read has a latency of one cycle. It sends a one-cycle return strobe to an external program counter.

Some instructions span two or three words. A word whose top nibble is `1111` is treated as operand data only when the previous first word asks for it. A word like this that arrives on its own does nothing. While an operation is still running, the block raises a stall output. The fetch side must then hold its word until stall is low. A single enable input turns the whole instruction group on or off.

Top module: `sxe_exec`

## Requirements
- R1: While reset is high, and in the first cycle after it, the stack pointer equals SP_RESET (default 0x000), and stall, return strobe, write strobe and read strobe are all low.
- R2: A word matching `1110 1000 11kk kkkk` adds the 6-bit k to the stack pointer. The return strobe is high for exactly the cycle after the word is accepted, and stall is high in that same single cycle.
- R3: A word matching `1110 1001 11kk kkkk` subtracts the 6-bit k from the stack pointer, with the same one-cycle return strobe and one-cycle stall as R2.
- R4: A word matching `1110 1010 kkkk kkkk` writes the 8-bit k to the address equal to the current stack pointer (upper address bits zero) and then decrements the pointer. It causes no stall and no return.
- R5: The first word `1110 1011 0sss ssss` followed by `1111 aaaa aaaa aaaa` reads the byte at stack pointer + s and writes it to the 14-bit address {00, a}. Stall is high for two cycles after the second word.
- R6: The first word `1110 1011 1sss ssss` followed by `1111 xxxx xddd dddd` reads the byte at stack pointer + s and writes it to stack pointer + d.
- R7: The first word `0000 0000 0000 0010`, then `1111 xxx sssssss hh`, then `1111 llll llll llll` reads the byte at stack pointer + s and writes it to the 14-bit address {hh, l}.
- R8: A word with top nibble `1111` that arrives as a first word changes nothing: no memory access, no return, no stall, and the pointer is unchanged.
- R9: While the enable input is low, none of these opcodes is recognised, and every word behaves as in R8.
- R10: Stack-pointer arithmetic and stack-relative addresses wrap modulo 4096. Stack-relative offsets are 7-bit unsigned.
- R11: If the word in an operand slot does not start with `1111`, the move is cancelled. No read and no write takes place, and the pointer is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ext_en_i | input | 1 | Enables the extended instruction group |
| iw_valid_i | input | 1 | Instruction word present; accepted when stall_o is low |
| iw_data_i | input | 16 | Instruction word |
| stall_o | output | 1 | Block busy; fetch must hold |
| sp_o | output | 12 | Current stack pointer |
| ret_o | output | 1 | One-cycle return strobe to the program counter |
| dm_addr_o | output | 14 | Data-memory address |
| dm_re_o | output | 1 | Data-memory read strobe |
| dm_we_o | output | 1 | Data-memory write strobe |
| dm_wdata_o | output | 8 | Data-memory write data |
| dm_rdata_i | input | 8 | Read data, valid the cycle after dm_re_o |

## Verification
The hardest case to reach is a stack-relative address that wraps past 0xFFF. The pointer has no load path, so the bench first pushes from the reset value of zero, which moves the pointer to 0xFFF. It then issues moves whose offsets carry the address through zero. A second hard case is a cancelled move. The bench puts an ordinary word into an operand slot. It then checks that no read or write appears and that the following instructions still decode as first words.

// File: rtl/sxe_pkg.sv
package sxe_pkg;
  localparam int IW_W  = 16;  // instruction word
  localparam int SP_W  = 12;  // stack pointer
  localparam int AW    = 14;  // data address
  localparam int OFF_W = 7;   // stack-relative offset
  localparam int KW    = 6;   // add/sub literal
  localparam int PW    = 8;   // push literal
  localparam int HI_W  = AW - SP_W;
  localparam logic [3:0] CONT_NIB = 4'hF;

  typedef enum logic [2:0] {
    OP_NONE, OP_ADDR, OP_SUBR, OP_PUSH, OP_MVSA, OP_MVSS, OP_MVLG
  } xop_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RETNOP, ST_OPND2, ST_OPND3, ST_RDWAIT, ST_WRITE
  } xst_e;

  typedef struct packed {
    xop_e             op;
    logic [PW-1:0]    lit;
    logic [OFF_W-1:0] soff;
  } xdec_t;
endpackage

// File: rtl/sxe_decode.sv
module sxe_decode
  import sxe_pkg::*;
(
  input  logic            en,
  input  logic [IW_W-1:0] word,
  output xdec_t           dec
);
  always_comb begin
    dec.op   = OP_NONE;
    dec.lit  = word[PW-1:0];
    dec.soff = word[OFF_W-1:0];
    if (en) begin
      if (word[15:6] == 10'b1110_1000_11)      dec.op = OP_ADDR;
      else if (word[15:6] == 10'b1110_1001_11) dec.op = OP_SUBR;
      else if (word[15:8] == 8'b1110_1010)     dec.op = OP_PUSH;
      else if (word[15:7] == 9'b1110_1011_0)   dec.op = OP_MVSA;
      else if (word[15:7] == 9'b1110_1011_1)   dec.op = OP_MVSS;
      else if (word == 16'h0002)               dec.op = OP_MVLG;
    end
  end
endmodule

// File: rtl/sxe_agu.sv
module sxe_agu #(
  parameter int SP_W  = 12,
  parameter int OFF_W = 7,
  parameter int AW    = 14
) (
  input  logic [SP_W-1:0]  sp,
  input  logic [OFF_W-1:0] off,
  output logic [AW-1:0]    addr
);
  localparam int PAD = AW - SP_W;
  logic [SP_W-1:0] sum;
  assign sum  = sp + SP_W'(off);
  assign addr = {{PAD{1'b0}}, sum};
endmodule

// File: rtl/sxe_sp.sv
module sxe_sp #(
  parameter int              SP_W     = 12,
  parameter int              KW       = 6,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            add_en,
  input  logic            sub_en,
  input  logic            dec_en,
  input  logic [KW-1:0]   lit,
  output logic [SP_W-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)         sp <= SP_RESET;
    else if (add_en) sp <= sp + SP_W'(lit);
    else if (sub_en) sp <= sp - SP_W'(lit);
    else if (dec_en) sp <= sp - SP_W'(1);
  end

  // R2/R3/R4: the controller never requests two pointer updates at once
  a_r2_single_sp_update: assert property (@(posedge clk) disable iff (rst)
    $onehot0({add_en, sub_en, dec_en}));
endmodule

// File: rtl/sxe_exec.sv
module sxe_exec
  import sxe_pkg::*;
#(
  parameter int              DW       = 8,
  parameter logic [SP_W-1:0] SP_RESET = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_en_i,
  input  logic            iw_valid_i,
  input  logic [IW_W-1:0] iw_data_i,
  output logic            stall_o,
  output logic [SP_W-1:0] sp_o,
  output logic            ret_o,
  output logic [AW-1:0]   dm_addr_o,
  output logic            dm_re_o,
  output logic            dm_we_o,
  output logic [DW-1:0]   dm_wdata_o,
  input  logic [DW-1:0]   dm_rdata_i
);
  xst_e st_q, st_n;
  xop_e op_q, op_n;
  logic [OFF_W-1:0] soff_q, soff_n;
  logic [AW-1:0]    dst_q, dst_n;
  logic [AW-1:0]    addr_n;
  logic [DW-1:0]    wdata_n;
  logic             we_n, re_n, ret_n, stall_n;
  logic             add_en, sub_en, dec_en;
  logic             acc, cont_ok;
  logic [AW-1:0]    src_addr, rel_dst, push_addr;
  xdec_t            dec;

  assign acc       = iw_valid_i && !stall_o;
  assign cont_ok   = (iw_data_i[IW_W-1:IW_W-4] == CONT_NIB);
  assign push_addr = {{HI_W{1'b0}}, sp_o};

  sxe_decode u_dec (.en(ext_en_i), .word(iw_data_i), .dec(dec));

  sxe_agu #(.SP_W(SP_W), .OFF_W(OFF_W), .AW(AW)) u_agu_src (
    .sp(sp_o), .off(soff_q), .addr(src_addr));

  sxe_agu #(.SP_W(SP_W), .OFF_W(OFF_W), .AW(AW)) u_agu_dst (
    .sp(sp_o), .off(iw_data_i[OFF_W-1:0]), .addr(rel_dst));

  sxe_sp #(.SP_W(SP_W), .KW(KW), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .add_en(add_en), .sub_en(sub_en),
    .dec_en(dec_en), .lit(dec.lit[KW-1:0]), .sp(sp_o));

  always_comb begin
    st_n    = st_q;
    op_n    = op_q;
    soff_n  = soff_q;
    dst_n   = dst_q;
    addr_n  = dm_addr_o;
    wdata_n = dm_wdata_o;
    we_n    = 1'b0;
    re_n    = 1'b0;
    ret_n   = 1'b0;
    add_en  = 1'b0;
    sub_en  = 1'b0;
    dec_en  = 1'b0;
    case (st_q)
      ST_IDLE: if (acc) begin
        case (dec.op)
          OP_ADDR: begin add_en = 1'b1; ret_n = 1'b1; st_n = ST_RETNOP; end
          OP_SUBR: begin sub_en = 1'b1; ret_n = 1'b1; st_n = ST_RETNOP; end
          OP_PUSH: begin
            dec_en  = 1'b1;
            we_n    = 1'b1;
            addr_n  = push_addr;
            wdata_n = DW'(dec.lit);
          end
          OP_MVSA, OP_MVSS: begin
            op_n = dec.op; soff_n = dec.soff; st_n = ST_OPND2;
          end
          OP_MVLG: begin op_n = dec.op; st_n = ST_OPND2; end
          default: ;
        endcase
      end
      ST_RETNOP: st_n = ST_IDLE;
      ST_OPND2: if (acc) begin
        if (!cont_ok) st_n = ST_IDLE;
        else begin
          case (op_q)
            OP_MVSA: begin
              dst_n = {{HI_W{1'b0}}, iw_data_i[SP_W-1:0]};
              re_n = 1'b1; addr_n = src_addr; st_n = ST_RDWAIT;
            end
            OP_MVSS: begin
              dst_n = rel_dst;
              re_n = 1'b1; addr_n = src_addr; st_n = ST_RDWAIT;
            end
            default: begin
              soff_n = iw_data_i[OFF_W+1:2];
              dst_n  = {iw_data_i[HI_W-1:0], {SP_W{1'b0}}};
              st_n   = ST_OPND3;
            end
          endcase
        end
      end
      ST_OPND3: if (acc) begin
        if (!cont_ok) st_n = ST_IDLE;
        else begin
          dst_n = {dst_q[AW-1:SP_W], iw_data_i[SP_W-1:0]};
          re_n = 1'b1; addr_n = src_addr; st_n = ST_RDWAIT;
        end
      end
      ST_RDWAIT: st_n = ST_WRITE;
      ST_WRITE: begin
        we_n = 1'b1; addr_n = dst_q; wdata_n = dm_rdata_i; st_n = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
    stall_n = (st_n == ST_RETNOP) || (st_n == ST_RDWAIT) || (st_n == ST_WRITE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= ST_IDLE;
      op_q       <= OP_NONE;
      soff_q     <= '0;
      dst_q      <= '0;
      dm_addr_o  <= '0;
      dm_wdata_o <= '0;
      dm_we_o    <= 1'b0;
      dm_re_o    <= 1'b0;
      ret_o      <= 1'b0;
      stall_o    <= 1'b0;
    end else begin
      st_q       <= st_n;
      op_q       <= op_n;
      soff_q     <= soff_n;
      dst_q      <= dst_n;
      dm_addr_o  <= addr_n;
      dm_wdata_o <= wdata_n;
      dm_we_o    <= we_n;
      dm_re_o    <= re_n;
      ret_o      <= ret_n;
      stall_o    <= stall_n;
    end
  end

  // R2: the return strobe lasts a single cycle
  a_r2_ret_single: assert property (@(posedge clk) disable iff (rst)
    ret_o |=> !ret_o);
  // R2: fetch is held while the return strobe is out
  a_r2_ret_stalls: assert property (@(posedge clk) disable iff (rst)
    ret_o |-> stall_o);
  // R3: the add/sub forms stall for exactly one cycle
  a_r3_stall_ends: assert property (@(posedge clk) disable iff (rst)
    ret_o |=> !stall_o);
  // R5: a move read is followed by a stalled write cycle
  a_r5_read_then_busy: assert property (@(posedge clk) disable iff (rst)
    dm_re_o |=> stall_o);
  // R5: reads and writes never overlap
  a_r5_no_rw_overlap: assert property (@(posedge clk) disable iff (rst)
    !(dm_we_o && dm_re_o));
  // R9: with the group disabled, an idle executor stays quiet
  a_r9_gated: assert property (@(posedge clk) disable iff (rst)
    (!ext_en_i && st_q == ST_IDLE) |=> (!dm_we_o && !ret_o && !stall_o));
endmodule

// File: tb/test_sxe_exec.sv
module test_sxe_exec;
  import sxe_pkg::*;
  localparam int DW = 8;

  typedef struct packed {
    logic [23:0]     tag;
    logic [1:0]      n;
    logic [15:0]     w1;
    logic [15:0]     w2;
    logic [15:0]     w3;
    logic [SP_W-1:0] dsp;
    logic [1:0]      wr;
    logic [1:0]      rt;
    logic [1:0]      stl;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{"R2 ", 2'd1, 16'hE8C5, 16'h0000, 16'h0000, 12'h005, 2'd0, 2'd1, 2'd1},
    '{"R3 ", 2'd1, 16'hE9C3, 16'h0000, 16'h0000, 12'hFFD, 2'd0, 2'd1, 2'd1},
    '{"R4 ", 2'd1, 16'hEAA5, 16'h0000, 16'h0000, 12'hFFF, 2'd1, 2'd0, 2'd0},
    '{"R8 ", 2'd1, 16'hF123, 16'h0000, 16'h0000, 12'h000, 2'd0, 2'd0, 2'd0},
    '{"R5 ", 2'd2, 16'hEB04, 16'hF234, 16'h0000, 12'h000, 2'd1, 2'd0, 2'd2},
    '{"R6 ", 2'd2, 16'hEB82, 16'hF009, 16'h0000, 12'h000, 2'd1, 2'd0, 2'd2},
    '{"R7 ", 2'd3, 16'h0002, 16'hF00F, 16'hFABC, 12'h000, 2'd1, 2'd0, 2'd2},
    '{"R2 ", 2'd1, 16'hE8FF, 16'h0000, 16'h0000, 12'h03F, 2'd0, 2'd1, 2'd1},
    '{"R3 ", 2'd1, 16'hE9FF, 16'h0000, 16'h0000, 12'hFC1, 2'd0, 2'd1, 2'd1},
    '{"R8 ", 2'd1, 16'h1234, 16'h0000, 16'h0000, 12'h000, 2'd0, 2'd0, 2'd0}
  };

  logic clk = 1'b0, rst = 1'b1, ext_en = 1'b1, iw_valid = 1'b0;
  logic [IW_W-1:0] iw_data = '0;
  logic [AW-1:0]   dm_addr;
  logic            dm_we, dm_re, ret, stall;
  logic [DW-1:0]   dm_wdata;
  logic [DW-1:0]   dm_rdata = '0;
  logic [SP_W-1:0] sp;

  always #10 clk = ~clk;

  sxe_exec i_sxe_exec (
    .clk(clk), .rst(rst), .ext_en_i(ext_en), .iw_valid_i(iw_valid),
    .iw_data_i(iw_data), .stall_o(stall), .sp_o(sp), .ret_o(ret),
    .dm_addr_o(dm_addr), .dm_re_o(dm_re), .dm_we_o(dm_we),
    .dm_wdata_o(dm_wdata), .dm_rdata_i(dm_rdata));

  function automatic logic [7:0] patt(input logic [AW-1:0] a);
    return a[7:0] ^ {2'b00, a[13:8]} ^ 8'h5A;
  endfunction

  int n_wr = 0, n_rd = 0, n_ret = 0, n_stl = 0;
  logic [AW-1:0] last_wa = '0, last_ra = '0;
  logic [7:0]    last_wd = '0;

  always @(posedge clk) begin
    if (dm_re) dm_rdata <= patt(dm_addr);
    if (!rst) begin
      if (dm_we) begin n_wr <= n_wr + 1; last_wa <= dm_addr; last_wd <= dm_wdata; end
      if (dm_re) begin n_rd <= n_rd + 1; last_ra <= dm_addr; end
      if (ret)   n_ret <= n_ret + 1;
      if (stall) n_stl <= n_stl + 1;
    end
  end

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    while (stall) @(negedge clk);
    iw_valid = 1'b1;
    iw_data  = w;
    @(negedge clk);
    iw_valid = 1'b0;
  endtask

  task automatic drain();
    repeat (5) @(negedge clk);
  endtask

  logic [SP_W-1:0] sp_m;
  int b_wr, b_rd, b_ret, b_stl;

  task automatic snap();
    b_wr = n_wr; b_rd = n_rd; b_ret = n_ret; b_stl = n_stl;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 sp", sp, 12'h000);
    chk("R1 stall", stall, 0);
    chk("R1 ret", ret, 0);
    chk("R1 we", dm_we, 0);
    chk("R1 re", dm_re, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sp after release", sp, 12'h000);

    // R4 push at pointer zero, R10 wrap to 0xFFF
    snap();
    send(16'hEA3C);
    drain();
    chk("R4 write count", n_wr - b_wr, 1);
    chk("R4 write addr", last_wa, 14'h0000);
    chk("R4 write data", last_wd, 8'h3C);
    chk("R10 sp wrap down", sp, 12'hFFF);
    chk("R4 no stall", n_stl - b_stl, 0);

    // R6 + R10: stack-relative move wrapping through zero
    snap();
    send(16'hEB84);
    send(16'hF07F);
    drain();
    chk("R10 read addr wraps", last_ra, 14'h0003);
    chk("R6 write addr", last_wa, 14'h007E);
    chk("R6 write data", last_wd, patt(14'h0003));
    chk("R6 stall cycles", n_stl - b_stl, 2);

    // R5: absolute destination with top bits forced to zero
    snap();
    send(16'hEB01);
    send(16'hFFFF);
    drain();
    chk("R5 read addr", last_ra, 14'h0000);
    chk("R5 write addr", last_wa, 14'h0FFF);
    chk("R5 write data", last_wd, patt(14'h0000));

    // R7: three-word move to a 14-bit destination
    snap();
    send(16'h0002);
    send(16'hF1FF);
    send(16'hF001);
    drain();
    chk("R7 read addr", last_ra, 14'h007E);
    chk("R7 write addr", last_wa, 14'h3001);
    chk("R7 write data", last_wd, patt(14'h007E));
    chk("R7 write count", n_wr - b_wr, 1);

    // R11: bad operand word cancels the move
    snap();
    send(16'hEB05);
    send(16'h1234);
    drain();
    chk("R11 no read", n_rd - b_rd, 0);
    chk("R11 no write", n_wr - b_wr, 0);
    chk("R11 no stall", n_stl - b_stl, 0);
    chk("R11 sp kept", sp, 12'hFFF);

    // R9: group disabled
    ext_en = 1'b0;
    snap();
    send(16'hE8C5);
    send(16'hEAA5);
    send(16'hEB01);
    send(16'hF123);
    send(16'h0002);
    drain();
    chk("R9 no write", n_wr - b_wr, 0);
    chk("R9 no read", n_rd - b_rd, 0);
    chk("R9 no ret", n_ret - b_ret, 0);
    chk("R9 no stall", n_stl - b_stl, 0);
    chk("R9 sp kept", sp, 12'hFFF);
    ext_en = 1'b1;

    // R2 + R10: add wraps upward
    snap();
    send(16'hE8C2);
    drain();
    chk("R10 sp wrap up", sp, 12'h001);
    chk("R2 ret pulses", n_ret - b_ret, 1);

    // table walk
    sp_m = 12'h001;
    for (int i = 0; i < NV; i++) begin
      snap();
      send(VEC[i].w1);
      if (VEC[i].n > 2'd1) send(VEC[i].w2);
      if (VEC[i].n > 2'd2) send(VEC[i].w3);
      drain();
      sp_m = sp_m + VEC[i].dsp;
      chk($sformatf("%s vec%0d sp", VEC[i].tag, i), sp, sp_m);
      chk($sformatf("%s vec%0d writes", VEC[i].tag, i), n_wr - b_wr, VEC[i].wr);
      chk($sformatf("%s vec%0d rets", VEC[i].tag, i), n_ret - b_ret, VEC[i].rt);
      chk($sformatf("%s vec%0d stalls", VEC[i].tag, i), n_stl - b_stl, VEC[i].stl);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule